// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial byte-oriented front end and gathers incoming data bytes into a 16-slot page buffer. The buffer is tagged with the upper seven bits of an 11-bit address. When the front end reports a STOP, the buffered bytes are copied into a 2048-byte internal array. The copy happens during a self-timed write cycle whose length is a clock-count parameter. The block raises `busy` for the whole cycle, and the front end uses it to withhold acknowledges.

The front end loads a start address with `addr_load`. Each `byte_wr` strobe then stores one byte at the current pointer and advances only the low four pointer bits. A transfer that runs past the end of the page, or that is longer than sixteen bytes, therefore wraps to the start of the same page and overwrites bytes written earlier. A per-slot valid mask restricts the commit to the slots actually written. A write-protect input, sampled at STOP, can discard the whole transfer. The stored array can be read at any time through a combinational read port.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset `busy` is low and no write cycle is pending.
- R2: A `byte_wr` accepted while idle stores `byte_in` in buffer slot `ptr[3:0]`. After it, `ptr[3:0]` is one higher modulo 16 and `ptr[10:4]` is unchanged. `addr_load` sets the pointer to `addr_in`, and it also empties the buffer.
- R3: When a transfer starts mid-page or carries more than 16 bytes, it wraps to slot 0 of the same page. In each slot the later byte replaces the earlier one, and no other page is touched.
- R4: The memory is written only after a `stop`. When `stop` arrives with at least one written slot and `wp` low, `busy` goes high on the next cycle and stays high for exactly WR_CYCLES cycles.
- R5: A commit changes only the slots written since the last `addr_load`. The other locations of the page keep their previous contents.
- R6: If `wp` is high in the cycle `stop` is seen, the buffered bytes are discarded, `busy` stays low and the memory is unchanged.
- R7: A `stop` with no bytes written since the last `addr_load` starts no write cycle, and `busy` stays low.
- R8: While `busy` is high, `byte_wr`, `addr_load` and `stop` are ignored. They change neither the memory nor the cycle length.
- R9: In the first cycle after `busy` falls, `rd_data` returns the committed bytes. The buffer is then empty, so a bare `stop` does not start another cycle.
- R10: A `byte_wr` in the same cycle as `stop` is included in the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load start address and empty the buffer |
| addr_in | input | 11 | Start address |
| byte_wr | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| stop | input | 1 | End of transfer |
| wp | input | 1 | Write protect, sampled with `stop` |
| busy | output | 1 | Write cycle in progress |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Stored byte at `rd_addr` (combinational) |

## Verification
The last data byte and the STOP can arrive in the same cycle. The bench provokes this by raising `byte_wr` and `stop` together on the final byte of some transfers. It judges the result by reading back the page after the cycle and expecting that byte to be present. A second collision comes from strobes driven during an active cycle: a foreign address, a data byte and a STOP are injected mid-cycle. The bench expects the cycle length to stay unchanged and both pages to keep their modelled contents.

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int ADDR_W    = 11,
  parameter int OFS_W     = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_wr,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop,
  input  logic              wp,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int SLOTS  = 1 << OFS_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic [PAGE_W-1:0] tag;
  logic [OFS_W-1:0]  ofs;
  logic [SLOTS-1:0]  vmask;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] pbuf [SLOTS];
  logic [DATA_W-1:0] mem  [DEPTH];

  wire                idle    = !busy;
  wire                wr_ok   = idle && byte_wr;
  wire  [OFS_W-1:0]   ofs_eff = addr_load ? addr_in[OFS_W-1:0] : ofs;
  wire  [SLOTS-1:0]   hit     = wr_ok ? (SLOTS'(1) << ofs_eff) : '0;
  wire  [SLOTS-1:0]   mask_nx = addr_load ? hit : (vmask | hit);
  wire                launch  = idle && stop && !wp && (|mask_nx);
  wire                done    = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      vmask <= '0;
      tag   <= '0;
      ofs   <= '0;
    end else if (idle) begin
      if (addr_load) begin
        tag <= addr_in[ADDR_W-1:OFS_W];
        ofs <= addr_in[OFS_W-1:0] + OFS_W'(byte_wr);
      end else if (byte_wr) begin
        ofs <= ofs + OFS_W'(1);
      end
      vmask <= (stop && !launch) ? '0 : mask_nx;
      if (launch) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(WR_CYCLES - 1);
      end
    end else if (done) begin
      busy  <= 1'b0;
      vmask <= '0;
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) pbuf[ofs_eff] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (done)
      for (int i = 0; i < SLOTS; i++)
        if (vmask[i]) mem[{tag, OFS_W'(i)}] <= pbuf[i];
  end

  assign rd_data = mem[rd_addr];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && byte_wr && !addr_load) |=> (ofs == $past(ofs) + OFS_W'(1)) && $stable(tag)); // R2
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && stop && !wp && (byte_wr || |vmask)) |=> busy); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy); // R4
  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && stop && wp) |=> !busy); // R6
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && stop && !byte_wr && vmask == '0) |=> !busy); // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> $stable(tag) && $stable(ofs)); // R8
  AST_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (vmask == '0)); // R9
endmodule

// File: tb/page_commit_ctrl_tb.sv
module page_commit_ctrl_tb;
  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_load = 1'b0;
  logic [10:0] addr_in = '0;
  logic        byte_wr = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        stop = 1'b0;
  logic        wp = 1'b0;
  logic        busy;
  logic [10:0] rd_addr = '0;
  logic [7:0]  rd_data;

  int checks = 0;
  int failures = 0;
  bit ended = 0;

  logic [7:0] mdl [2048];
  bit         known [2048];

  page_commit_ctrl #(.WR_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_wr(byte_wr), .byte_in(byte_in), .stop(stop), .wp(wp),
    .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data));

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic chk_page(input string tag, input int page);
    for (int i = 0; i < 16; i++) begin
      rd_addr = 11'(page * 16 + i);
      #1;
      if (known[page * 16 + i]) check(tag, int'(rd_data), int'(mdl[page * 16 + i]));
    end
  endtask

  // one transfer: address, n bytes, stop; optional same-cycle stop and meddling while busy
  task automatic txn(input int page, input int ofs, input int n, input int seed,
                     input bit prot, input bit same, input bit meddle);
    logic [7:0] pb [16];
    bit pm [16];
    int o, cyc, other;
    bit any;
    for (int i = 0; i < 16; i++) pm[i] = 0;
    @(negedge clk);
    addr_load = 1'b1; addr_in = 11'(page * 16 + ofs);
    @(negedge clk);
    addr_load = 1'b0;
    o = ofs;
    for (int k = 0; k < n; k++) begin
      byte_wr = 1'b1;
      byte_in = 8'((seed * 7 + k * 13 + 5) & 255);
      pb[o] = byte_in; pm[o] = 1; o = (o + 1) % 16;
      if (same && k == n - 1) begin stop = 1'b1; wp = prot; end
      @(negedge clk);
      byte_wr = 1'b0;
    end
    if (!(same && n > 0)) begin
      stop = 1'b1; wp = prot;
      @(negedge clk);
    end
    stop = 1'b0; wp = 1'b0;
    any = 0;
    for (int i = 0; i < 16; i++) if (pm[i]) any = 1;
    if (prot)      check("R6 busy stays low under wp", int'(busy), 0);
    else if (!any) check("R7 no cycle without data", int'(busy), 0);
    else if (same) check("R10 busy after same-cycle stop", int'(busy), 1);
    else           check("R4 busy after stop", int'(busy), 1);
    if (busy) begin
      cyc = 1;
      other = (page + 1) % 128;
      forever begin
        if (meddle && cyc == 3) begin
          addr_load = 1'b1; addr_in = 11'(other * 16);
          byte_wr = 1'b1; byte_in = 8'hEE; stop = 1'b1;
        end
        @(negedge clk);
        addr_load = 1'b0; byte_wr = 1'b0; stop = 1'b0;
        if (!busy) break;
        cyc++;
      end
      check(meddle ? "R8 cycle length with strobes" : "R4 cycle length", cyc, W);
      for (int i = 0; i < 16; i++)
        if (pm[i]) begin mdl[page * 16 + i] = pb[i]; known[page * 16 + i] = 1; end
      chk_page(same ? "R10 page contents" : "R9 read after busy falls", page);
      if (meddle) chk_page("R8 other page untouched", other);
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check("R9 buffer empty after commit", int'(busy), 0);
    end else begin
      chk_page(prot ? "R6 memory unchanged" : "R7 memory unchanged", page);
    end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int pages [3];
    int offs [3];
    int cnts [4];
    int s;
    pages = '{0, 5, 127};
    offs = '{0, 3, 15};
    cnts = '{1, 16, 17, 20};
    for (int i = 0; i < 2048; i++) known[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 busy low in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy low after reset", int'(busy), 0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R1 nothing pending", int'(busy), 0);
    s = 1;
    for (int p = 0; p < 3; p++) begin
      txn(pages[p], 0, 16, s, 0, 0, 0); s++;
      for (int f = 0; f < 3; f++)
        for (int c = 0; c < 4; c++) begin
          // R2 R3 R5: wrap and partial update judged by page readback
          txn(pages[p], offs[f], cnts[c], s, 0, (c == 1), 0);
          s++;
        end
    end
    txn(5, 2, 6, 200, 1, 0, 0);
    txn(5, 9, 1, 201, 1, 1, 0);
    txn(127, 4, 0, 202, 0, 0, 0);
    txn(0, 7, 5, 203, 0, 0, 1);
    txn(0, 0, 3, 204, 0, 1, 1);
    finish_run();
  end
endmodule